// File: doc/BRIEF.md
# Associative-Data SRAM Address Sequencer

This block sits between the instruction decoder of a lookup coprocessor and the address pins of an external SRAM that holds the data associated with each table entry. It accepts four instruction types: register-style SRAM read, register-style SRAM write, search, and learn. For each one it forms a 24-bit SRAM address and places it on the SRAM bus after a configurable pipeline latency, with a one-cycle valid strobe.

The address has four parts. Three control bits pass straight through from the instruction. The upper four bits of the device identifier follow, then a bank bit, then a 16-bit low field. The source of the low field depends on the instruction. For a search, it is the hit index, aligned down to the page boundary of the configured table width. For a register-style access, it is the address carried on the data bus. For a learn, it is either the next-free-entry value or the search-status value.

Reads are blocking. After a read is accepted, the block refuses all new instructions until a read acknowledge returns. The acknowledge arrives a further configurable number of cycles after the address. Writes occupy two instruction cycles and are otherwise pipelined. Any instruction that cannot be taken is discarded and flagged in the same cycle.

Top module: `sram_addr_seq`

## Requirements
- R1: `sram_addr` is built as {`cmd_ctl`[2:0] in bits 23:21, `dev_id`[4:1] in bits 20:17, `bank_sel` in bit 16, low field in bits 15:0}. All parts are sampled in the cycle the instruction is accepted.
- R2: For a search (`cmd_op`=2), the low field is `hit_index` aligned to the page for the value of `table_mode`:
  - 0 (72-bit): unchanged.
  - 1 (144-bit): bit 0 cleared.
  - 2 or 3 (288-bit): bits 1:0 cleared.
- R3: For a register-style read or write (`cmd_op`=0 or 1), the low field is `dq_addr`. For a learn (`cmd_op`=3), the low field is `ssr_val` when `learn_ssr`=1 and `nfa_val` otherwise.
- R4: The latency is L = 2^`cfg_tlsz` (1, 2, 4 or 8 cycles), sampled at acceptance. For a read or search accepted at clock edge e, `sram_av` and the address appear in the cycle that starts at edge e+L.
- R5: Writes (`cmd_op`=1 or 3) are two-cycle instructions. `ready` is low in the cycle after acceptance. The address appears at edge e+1+L, so latency counts from the second instruction cycle.
- R6: For a register-style read accepted at edge e, `ack` is high for exactly one cycle, starting at edge e+L+H, where H = `cfg_hlat` (0 to 7) sampled at acceptance. No other instruction produces `ack`.
- R7: After an accepted read, `ready` stays low from edge e until edge e+L+H. It is high again in the cycle in which `ack` is high.
- R8: When `cmd_valid` is high and `ready` is low, the instruction is ignored. In that case `cmd_drop` is high in the same cycle, and no address or acknowledge results from the instruction.
- R9: An instruction whose address would leave in the same cycle as an address already scheduled is ignored and flagged with `cmd_drop`. This case arises when different latencies are mixed. `cmd_drop` is low whenever `cmd_valid` is low.
- R10: `sram_av` is high for exactly one cycle per scheduled address. `sram_addr` is zero in every cycle in which `sram_av` is low.
- R11: While `rst_n` is low, `ready` is 1 and `sram_av`, `ack` and `sram_addr` are 0. Any instructions in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction present this cycle |
| cmd_op | input | 2 | 0 register read, 1 register write, 2 search, 3 learn |
| cmd_ctl | input | 3 | Control bits copied into address bits 23:21 |
| dq_addr | input | 16 | Address carried on the data bus for register-style access |
| hit_index | input | 16 | Index of the matching 72-bit entry for a search |
| nfa_val | input | 16 | Next-free-entry value used by learn |
| ssr_val | input | 16 | Search-status value used by learn |
| learn_ssr | input | 1 | Learn takes its low field from `ssr_val` when 1 |
| bank_sel | input | 1 | Bank bit copied into address bit 16 |
| dev_id | input | 4 | Device identifier bits 4:1 |
| table_mode | input | 2 | Table entry width: 0 is 72-bit, 1 is 144-bit, 2 or 3 is 288-bit |
| cfg_tlsz | input | 2 | Pipeline latency select, L = 2^value |
| cfg_hlat | input | 3 | Extra acknowledge delay for reads |
| ready | output | 1 | Block can accept an instruction this cycle |
| cmd_drop | output | 1 | Presented instruction was ignored |
| sram_addr | output | 24 | SRAM address |
| sram_av | output | 1 | SRAM address valid strobe |
| ack | output | 1 | Read acknowledge |

## Verification
A corrupted slot in the latency line shows at the SRAM pins within at most eight cycles. It appears as a strobe in the wrong cycle, a wrong or nonzero idle address, or a false collision drop on a later instruction. A wrong blocking counter shows at once as `ready` returning too early or too late, with `ack` off its expected cycle. A failed write-phase flag shows in the very next cycle as an accepted or dropped instruction that should have been the opposite. The reference model predicts `ready`, `cmd_drop`, `sram_av`, `sram_addr` and `ack` in every cycle, so any of these faults is seen in the first cycle it affects a port.

// File: rtl/sram_addr_seq.sv
module sram_addr_seq #(
  parameter int LOW_W  = 16,
  parameter int CTL_W  = 3,
  parameter int IDH_W  = 4,
  parameter int TLSZ_W = 2,
  parameter int HLAT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [CTL_W-1:0]           cmd_ctl,
  input  logic [LOW_W-1:0]           dq_addr,
  input  logic [LOW_W-1:0]           hit_index,
  input  logic [LOW_W-1:0]           nfa_val,
  input  logic [LOW_W-1:0]           ssr_val,
  input  logic                       learn_ssr,
  input  logic                       bank_sel,
  input  logic [IDH_W:1]             dev_id,
  input  logic [1:0]                 table_mode,
  input  logic [TLSZ_W-1:0]          cfg_tlsz,
  input  logic [HLAT_W-1:0]          cfg_hlat,
  output logic                       ready,
  output logic                       cmd_drop,
  output logic [CTL_W+IDH_W+LOW_W:0] sram_addr,
  output logic                       sram_av,
  output logic                       ack
);
  localparam int AW    = CTL_W + IDH_W + 1 + LOW_W;
  localparam int DEPTH = 1 << ((1 << TLSZ_W) - 1);
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + (1 << HLAT_W)) + 1;

  logic [AW-1:0]    pipe_a [DEPTH];
  logic [DEPTH-1:0] pipe_v, v_nxt;
  logic [2*DEPTH-1:0] v_ext;
  logic             busy, wr2;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    wr_a, new_a;
  logic [IW-1:0]    wr_slot, slot;
  logic [IW:0]      probe;
  logic [LOW_W-1:0] low, page_mask;
  logic             is_wr, clash, accept, ins_rd;

  assign is_wr = cmd_op[0];
  assign slot  = IW'((1 << cfg_tlsz) - 1);

  always_comb begin
    case (table_mode)
      2'd0:    page_mask = '1;
      2'd1:    page_mask = ~LOW_W'(1);
      default: page_mask = ~LOW_W'(3);
    endcase
    case (cmd_op)
      2'd2:    low = hit_index & page_mask;
      2'd3:    low = learn_ssr ? ssr_val : nfa_val;
      default: low = dq_addr;
    endcase
  end

  assign new_a    = {cmd_ctl, dev_id, bank_sel, low};
  assign v_ext    = {{DEPTH{1'b0}}, pipe_v};
  assign probe    = {1'b0, slot} + (is_wr ? (IW+1)'(2) : (IW+1)'(1));
  assign clash    = v_ext[probe];
  assign ready    = !busy && !wr2;
  assign accept   = cmd_valid && ready && !clash;
  assign cmd_drop = cmd_valid && !accept;
  assign ins_rd   = accept && !is_wr;

  always_comb begin
    v_nxt = pipe_v >> 1;
    if (ins_rd) v_nxt[slot] = 1'b1;
    if (wr2)    v_nxt[wr_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH - 1; i++) pipe_a[i] <= pipe_a[i+1];
    if (ins_rd) pipe_a[slot] <= new_a;
    if (wr2)    pipe_a[wr_slot] <= wr_a;
    if (accept && is_wr) begin
      wr_a    <= new_a;
      wr_slot <= slot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_v    <= '0;
      wr2       <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      ack       <= 1'b0;
      sram_av   <= 1'b0;
      sram_addr <= '0;
    end else begin
      pipe_v    <= v_nxt;
      wr2       <= accept && is_wr;
      sram_av   <= pipe_v[0];
      sram_addr <= pipe_v[0] ? pipe_a[0] : '0;
      ack       <= busy && (cnt == '0);
      if (accept && cmd_op == 2'd0) begin
        busy <= 1'b1;
        cnt  <= CW'(slot) + CW'(cfg_hlat);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram_addr_seq_chk.sv
module sram_addr_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          ready,
  input logic          cmd_drop,
  input logic          sram_av,
  input logic [AW-1:0] sram_addr,
  input logic          ack
);
  // R10
  idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_av |-> sram_addr == '0);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !ready |-> cmd_drop);

  // R9
  drop_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |-> cmd_valid);

  // R7
  ack_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ready);

  // R7
  read_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_drop && cmd_op == 2'd0 |=> !ready);

  // R5
  write_second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_drop && cmd_op[0] |=> !ready);

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

bind sram_addr_seq sram_addr_seq_chk #(.AW(CTL_W + IDH_W + LOW_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .ready(ready), .cmd_drop(cmd_drop), .sram_av(sram_av),
  .sram_addr(sram_addr), .ack(ack)
);

// File: tb/test_sram_addr_seq.sv
`timescale 1ns/1ps
module test_sram_addr_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cmd_valid, learn_ssr, bank_sel;
  logic [1:0]  cmd_op, table_mode, cfg_tlsz;
  logic [2:0]  cmd_ctl, cfg_hlat;
  logic [15:0] dq_addr, hit_index, nfa_val, ssr_val;
  logic [4:1]  dev_id;
  wire         ready, cmd_drop, sram_av, ack;
  wire  [23:0] sram_addr;

  sram_addr_seq i_sram_addr_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ctl(cmd_ctl), .dq_addr(dq_addr), .hit_index(hit_index),
    .nfa_val(nfa_val), .ssr_val(ssr_val), .learn_ssr(learn_ssr),
    .bank_sel(bank_sel), .dev_id(dev_id), .table_mode(table_mode),
    .cfg_tlsz(cfg_tlsz), .cfg_hlat(cfg_hlat), .ready(ready),
    .cmd_drop(cmd_drop), .sram_addr(sram_addr), .sram_av(sram_av), .ack(ack)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, rd_s = 0, rd_e = 0, wr_c = -1;
  bit done = 0;
  logic [23:0] exp_addr [int];
  bit          exp_ack  [int];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [23:0] model_addr();
    logic [15:0] lo;
    case (cmd_op)
      2'd2: lo = hit_index & (table_mode == 2'd0 ? 16'hFFFF :
                              table_mode == 2'd1 ? 16'hFFFE : 16'hFFFC);
      2'd3: lo = learn_ssr ? ssr_val : nfa_val;
      default: lo = dq_addr;
    endcase
    return {cmd_ctl, dev_id, bank_sel, lo};
  endfunction

  task automatic tick();
    bit r, acc;
    int lat, tgt;
    #1;
    r   = !(cyc >= rd_s && cyc < rd_e) && (cyc != wr_c);
    lat = 1 << cfg_tlsz;
    tgt = cyc + 1 + lat + (cmd_op[0] ? 1 : 0);
    acc = cmd_valid && r && !exp_addr.exists(tgt);
    check("R5 R7", "ready", 32'(ready), 32'(r));
    check("R8 R9", "cmd_drop", 32'(cmd_drop), 32'(cmd_valid && !acc));
    if (acc) begin
      exp_addr[tgt] = model_addr();
      if (cmd_op == 2'd0) begin
        rd_s = cyc + 1;
        rd_e = cyc + 1 + lat + int'(cfg_hlat);
        exp_ack[rd_e] = 1'b1;
      end
      if (cmd_op[0]) wr_c = cyc + 1;
    end
    @(negedge clk);
    cyc++;
    check("R4 R5 R10", "sram_av", 32'(sram_av), 32'(exp_addr.exists(cyc)));
    check("R1 R2 R3", "sram_addr", 32'(sram_addr), exp_addr.exists(cyc) ? 32'(exp_addr[cyc]) : 32'h0);
    check("R6", "ack", 32'(ack), 32'(exp_ack.exists(cyc)));
  endtask

  task automatic issue(logic [1:0] op, int tl, int hl);
    cmd_valid = 1'b1; cmd_op = op; cfg_tlsz = 2'(tl); cfg_hlat = 3'(hl);
    cmd_ctl = 3'($urandom); dq_addr = 16'($urandom); hit_index = 16'($urandom);
    nfa_val = 16'($urandom); ssr_val = 16'($urandom); learn_ssr = 1'($urandom);
    bank_sel = 1'($urandom); dev_id = 4'($urandom);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin cmd_valid = 1'b0; tick(); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; table_mode = 2'd0;
    cfg_tlsz = 2'd0; cfg_hlat = 3'd0; cmd_ctl = '0; dq_addr = '0; hit_index = '0;
    nfa_val = '0; ssr_val = '0; learn_ssr = 1'b0; bank_sel = 1'b0; dev_id = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "ready", 32'(ready), 32'h1);
    check("R11", "sram_av", 32'(sram_av), 32'h0);
    check("R11", "ack", 32'(ack), 32'h0);
    check("R11", "sram_addr", 32'(sram_addr), 32'h0);
    rst_n = 1'b1;

    // R2 R4: searches over all latencies and table widths
    table_mode = 2'd0; issue(2'd2, 0, 0); idle(3);
    issue(2'd2, 1, 0); idle(4);
    table_mode = 2'd1; issue(2'd2, 2, 0); idle(6);
    table_mode = 2'd2; issue(2'd2, 3, 0); idle(10);
    table_mode = 2'd3; issue(2'd2, 0, 0); idle(2);

    // R5 R3: writes and learns, one presented in a second write cycle
    issue(2'd1, 0, 0); issue(2'd1, 2, 0); idle(1);
    issue(2'd3, 1, 0); idle(1); issue(2'd3, 0, 0); idle(1);
    issue(2'd3, 3, 0); idle(12);

    // R6 R7 R8: blocking reads with instructions presented while busy
    issue(2'd0, 0, 0); idle(3);
    issue(2'd0, 1, 5); issue(2'd2, 0, 0); issue(2'd1, 0, 0); idle(12);
    issue(2'd0, 3, 7); idle(20);

    // R9: collisions between mixed latencies
    issue(2'd2, 2, 0); idle(1); issue(2'd2, 1, 0); idle(8);
    issue(2'd2, 2, 0); issue(2'd1, 1, 0); idle(8);
    issue(2'd2, 3, 0); issue(2'd2, 2, 0); issue(2'd2, 1, 0); idle(12);

    // mixed traffic
    for (int k = 0; k < 500; k++) begin
      table_mode = 2'($urandom);
      if ($urandom % 3 != 0) issue(2'($urandom), int'($urandom % 4), int'($urandom % 8));
      else idle(1);
    end
    idle(24);
    finish_run();
  end
endmodule